// File: doc/BRIEF.md
# Packed-BCD Calendar Clock with Alarm Match

The block keeps the time of day and the date (seconds, minutes, hours, day of month, month and a two-digit year), each field one packed-BCD byte. A free-running slow tick enable, nominally 32.768 kHz, feeds a prescaler. Once per `TICKS_PER_SEC` ticks, the whole calendar advances by one second. The rollover honours month lengths and leap years.

Software reaches the clock over a simple byte-wide register bus. It can start or stop the clock, load any field at any time, and program a six-field alarm. That alarm must match the running time exactly; no field can be masked. Sticky status flags report the one-second, minute, hour and day carries and the alarm hit. Two interrupt outputs are masked by enable bits.

A BUSY status bit is high during the final tick period before each update. Software that waits for it to fall gets a safe window to read or load the time coherently.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00. The alarm fields hold the same values. The control, status and interrupt-enable registers read 0x00, and both interrupt outputs are low.
- R2: Seconds and minutes count 0x00 to 0x59 in BCD and hours count 0x00 to 0x23. Each wrap to 0x00 carries one into the next field in the same update.
- R3: The day wraps to 0x01 after the last day of the month and carries into the month. The last day is 0x31, 0x30 for months 0x04, 0x06, 0x09 and 0x11, and for month 0x02 it is 0x29 when the BCD year is a multiple of four (0x28 otherwise). Month wraps from 0x12 to 0x01 into the year, and the year wraps from 0x99 to 0x00.
- R4: Control register 0x40 bit 0 = 1 runs the clock and status bit 1 reads it back. While it is 0 the tick has no effect on any time field, and the prescaler is held at zero, so a restart gives a full second before the first update.
- R5: The time advances exactly once every `TICKS_PER_SEC` ticks while running. Status register 0x44 bit 0 (BUSY) is 1 exactly during the last tick period before each update and is never 1 while stopped.
- R6: A bus write to a time field (seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14) takes effect at the next clock edge, whether the clock is stopped or running. The new value reads back in the following cycle.
- R7: The alarm fields sit at 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 in the same field order. Status bit 6 becomes 1 at the update whose new time equals all six alarm fields. A single differing field prevents it. Writing 1 to bit 6 of 0x44 clears it.
- R8: Status bits 2, 3, 4 and 5 become 1 at every update, at an update that wraps seconds, at one that wraps minutes, and at one that wraps hours, respectively. They stay set until software writes 1 to the same bit of 0x44.
- R9: `irq_alarm` is status bit 6 gated by bit 3 of the interrupt-enable register 0x48. `irq_timer` is status bit 2 gated by bit 2 of 0x48. Clearing an enable drops the output without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per slow oscillator period |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_alarm | output | 1 | Masked alarm interrupt |
| irq_timer | output | 1 | Masked one-second interrupt |

## Verification
The bench targets the calendar edges: the last day of every month across leap and common years, the December-to-January carry, and the 0x99-to-0x00 year wrap. A design that mishandled these would land on day 0x32, skip February 29, or carry a BCD digit into 0x0A. A sweep across a midnight-and-new-year boundary checks each second and each event flag against an arithmetic model. This catches a carry that lands one second late, or a flag raised on the wrong field.

The alarm is checked both as a hit and as a near miss in only the year field, which exposes a partial comparison. Further checks show that BUSY rises exactly one tick before the update and that a stopped clock ignores ticks. They also confirm that masking an interrupt hides the output but keeps the flag.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NFIELD = 6;

    // field index; the byte address of field i is 4*i (alarm: 0x20 + 4*i)
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;

    typedef logic [NFIELD-1:0][7:0] cal_t;

    localparam cal_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    localparam logic [7:0] A_CTRL   = 8'h40;
    localparam logic [7:0] A_STAT   = 8'h44;
    localparam logic [7:0] A_IEN    = 8'h48;
    localparam logic [7:0] A_ALARM0 = 8'h20;

    // status bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_RUN   = 1;
    localparam int ST_SEC   = 2;
    localparam int ST_MIN   = 3;
    localparam int ST_HOUR  = 4;
    localparam int ST_DAY   = 5;
    localparam int ST_ALARM = 6;

    // interrupt-enable bit positions
    localparam int IE_TIMER = 2;
    localparam int IE_ALARM = 3;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year multiple of four: even tens need ones 0/4/8, odd tens need 2/6
    function automatic logic bcd_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] bcd_last_day(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick_en,
    output logic busy,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t pre_q, pre_d;

    always_comb begin
        pre_d     = pre_q;
        sec_pulse = 1'b0;
        if (!run) begin
            pre_d.cnt = '0;
        end else if (tick_en) begin
            if (pre_q.cnt == LAST) begin
                pre_d.cnt = '0;
                sec_pulse = 1'b1;
            end else begin
                pre_d.cnt = pre_q.cnt + 1'b1;
            end
        end
        busy = run && (pre_q.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [NFIELD-1:0] wr_en,
    input  logic [7:0]        wr_data,
    output cal_t              cal_now,
    output cal_t              cal_next,
    output logic              ev_min,
    output logic              ev_hour,
    output logic              ev_day
);
    typedef struct packed {
        cal_t cal;
    } cal_st_t;

    cal_st_t st_q, st_d;
    logic c_min, c_hour, c_day, c_mon, c_year;

    always_comb begin
        st_d   = st_q;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        if (step) begin
            if (st_q.cal[F_SEC] == 8'h59) begin
                st_d.cal[F_SEC] = 8'h00;
                c_min = 1'b1;
            end else begin
                st_d.cal[F_SEC] = bcd_inc(st_q.cal[F_SEC]);
            end
            if (c_min) begin
                if (st_q.cal[F_MIN] == 8'h59) begin
                    st_d.cal[F_MIN] = 8'h00;
                    c_hour = 1'b1;
                end else begin
                    st_d.cal[F_MIN] = bcd_inc(st_q.cal[F_MIN]);
                end
            end
            if (c_hour) begin
                if (st_q.cal[F_HOUR] == 8'h23) begin
                    st_d.cal[F_HOUR] = 8'h00;
                    c_day = 1'b1;
                end else begin
                    st_d.cal[F_HOUR] = bcd_inc(st_q.cal[F_HOUR]);
                end
            end
            if (c_day) begin
                if (st_q.cal[F_DAY] == bcd_last_day(st_q.cal[F_MON], st_q.cal[F_YEAR])) begin
                    st_d.cal[F_DAY] = 8'h01;
                    c_mon = 1'b1;
                end else begin
                    st_d.cal[F_DAY] = bcd_inc(st_q.cal[F_DAY]);
                end
            end
            if (c_mon) begin
                if (st_q.cal[F_MON] == 8'h12) begin
                    st_d.cal[F_MON] = 8'h01;
                    c_year = 1'b1;
                end else begin
                    st_d.cal[F_MON] = bcd_inc(st_q.cal[F_MON]);
                end
            end
            if (c_year) begin
                if (st_q.cal[F_YEAR] == 8'h99) st_d.cal[F_YEAR] = 8'h00;
                else                           st_d.cal[F_YEAR] = bcd_inc(st_q.cal[F_YEAR]);
            end
        end
        // a bus write wins over the carry for the field it targets
        for (int i = 0; i < NFIELD; i++) begin
            if (wr_en[i]) st_d.cal[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cal <= CAL_RESET;
        else        st_q     <= st_d;
    end

    assign cal_now  = st_q.cal;
    assign cal_next = st_d.cal;
    assign ev_min   = c_min;
    assign ev_hour  = c_hour;
    assign ev_day   = c_day;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [NFIELD-1:0] wr_en,
    input  logic [7:0]        wr_data,
    input  cal_t              cal_next,
    output cal_t              alm_now,
    output logic              hit
);
    typedef struct packed {
        cal_t alm;
    } alm_st_t;

    alm_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NFIELD; i++) begin
            if (wr_en[i]) st_d.alm[i] = wr_data;
        end
        // every field must match: no field is ever a don't-care
        hit = step && (cal_next == st_q.alm);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.alm <= CAL_RESET;
        else        st_q     <= st_d;
    end

    assign alm_now = st_q.alm;
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_alarm,
    output logic       irq_timer
);
    typedef struct packed {
        logic                 run;
        logic [ST_ALARM:ST_SEC] flags;
        logic                 ie_alarm;
        logic                 ie_timer;
    } top_t;

    top_t top_q, top_d;

    logic [NFIELD-1:0] time_wr_en, alm_wr_en;
    logic busy, sec_pulse, time_wr;
    logic ev_min, ev_hour, ev_day, alarm_hit;
    logic alarm_flag, min_flag;
    cal_t cal_now, cal_next, alm_now;

    for (genvar g = 0; g < NFIELD; g++) begin : g_dec
        assign time_wr_en[g] = bus_wr && (bus_addr == 8'(4 * g));
        assign alm_wr_en[g]  = bus_wr && (bus_addr == 8'(A_ALARM0 + 8'(4 * g)));
    end
    assign time_wr = |time_wr_en;

    rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (top_q.run),
        .tick_en   (tick_en),
        .busy      (busy),
        .sec_pulse (sec_pulse)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (sec_pulse),
        .wr_en    (time_wr_en),
        .wr_data  (bus_wdata),
        .cal_now  (cal_now),
        .cal_next (cal_next),
        .ev_min   (ev_min),
        .ev_hour  (ev_hour),
        .ev_day   (ev_day)
    );

    rtc_alarm u_alm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (sec_pulse),
        .wr_en    (alm_wr_en),
        .wr_data  (bus_wdata),
        .cal_next (cal_next),
        .alm_now  (alm_now),
        .hit      (alarm_hit)
    );

    always_comb begin
        top_d = top_q;
        if (bus_wr && bus_addr == A_CTRL) top_d.run = bus_wdata[0];
        if (bus_wr && bus_addr == A_IEN) begin
            top_d.ie_timer = bus_wdata[IE_TIMER];
            top_d.ie_alarm = bus_wdata[IE_ALARM];
        end
        if (bus_wr && bus_addr == A_STAT)
            top_d.flags = top_q.flags & ~bus_wdata[ST_ALARM:ST_SEC];
        // a new event wins over a clear in the same cycle
        if (sec_pulse) top_d.flags[ST_SEC]   = 1'b1;
        if (ev_min)    top_d.flags[ST_MIN]   = 1'b1;
        if (ev_hour)   top_d.flags[ST_HOUR]  = 1'b1;
        if (ev_day)    top_d.flags[ST_DAY]   = 1'b1;
        if (alarm_hit) top_d.flags[ST_ALARM] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr[7:5] == 3'b000 && bus_addr[1:0] == 2'b00 && bus_addr[4:2] < 3'(NFIELD))
            bus_rdata = cal_now[bus_addr[4:2]];
        else if (bus_addr[7:5] == 3'b001 && bus_addr[1:0] == 2'b00 && bus_addr[4:2] < 3'(NFIELD))
            bus_rdata = alm_now[bus_addr[4:2]];
        else if (bus_addr == A_CTRL)
            bus_rdata = {7'd0, top_q.run};
        else if (bus_addr == A_STAT)
            bus_rdata = {1'b0, top_q.flags, top_q.run, busy};
        else if (bus_addr == A_IEN)
            bus_rdata = {4'd0, top_q.ie_alarm, top_q.ie_timer, 2'd0};
    end

    assign alarm_flag = top_q.flags[ST_ALARM];
    assign min_flag   = top_q.flags[ST_MIN];
    assign irq_alarm  = top_q.flags[ST_ALARM] & top_q.ie_alarm;
    assign irq_timer  = top_q.flags[ST_SEC] & top_q.ie_timer;
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        running,
    input logic        busy,
    input logic        sec_pulse,
    input logic        time_wr,
    input logic [47:0] cal,
    input logic        alarm_flag,
    input logic        min_flag
);
    AST_BUSY_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> running); // R5

    AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !time_wr) |=> $stable(cal)); // R4

    AST_SEC_MOVES_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cal[7:0]) && !$past(time_wr)) |-> $past(busy)); // R5

    AST_ALARM_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_pulse)); // R7

    AST_MIN_EVENT_SEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(min_flag) && !$past(time_wr)) |-> (cal[7:0] == 8'h00)); // R8
endmodule

bind rtc_cal_top rtc_cal_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (top_q.run),
    .busy       (busy),
    .sec_pulse  (sec_pulse),
    .time_wr    (time_wr),
    .cal        (cal_now),
    .alarm_flag (alarm_flag),
    .min_flag   (min_flag)
);

// File: tb/sim_rtc_cal_top.sv
`timescale 1ns/100ps
module sim_rtc_cal_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_alarm, irq_timer;

    int n_chk = 0;
    int n_err = 0;

    rtc_cal_top #(.TICKS_PER_SEC(TPS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_alarm(irq_alarm), .irq_timer(irq_timer)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // all bus tasks start in the low clock phase
    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wait_sec(input int n);
        repeat (n * TPS) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic load(input int s, input int mi, input int h, input int d, input int mo, input int y);
        wr(8'h40, 8'h00);
        wr(8'h00, bcd(s));
        wr(8'h04, bcd(mi));
        wr(8'h08, bcd(h));
        wr(8'h0C, bcd(d));
        wr(8'h10, bcd(mo));
        wr(8'h14, bcd(y));
        wr(8'h44, 8'h7C);
    endtask

    task automatic load_alarm(input int s, input int mi, input int h, input int d, input int mo, input int y);
        wr(8'h20, bcd(s));
        wr(8'h24, bcd(mi));
        wr(8'h28, bcd(h));
        wr(8'h2C, bcd(d));
        wr(8'h30, bcd(mo));
        wr(8'h34, bcd(y));
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int s, mi, h, d, mo, y;
        int years [4] = '{0, 1, 96, 99};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick_en = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk("R1", "sec", v, 8'h00);
        rd(8'h0C, v); chk("R1", "day", v, 8'h01);
        rd(8'h10, v); chk("R1", "month", v, 8'h01);
        rd(8'h14, v); chk("R1", "year", v, 8'h00);
        rd(8'h2C, v); chk("R1", "alarm day", v, 8'h01);
        rd(8'h40, v); chk("R1", "ctrl", v, 8'h00);
        rd(8'h44, v); chk("R1", "status", v, 8'h00);
        rd(8'h48, v); chk("R1", "ienable", v, 8'h00);
        chk("R1", "irq pins", {irq_alarm, irq_timer}, 0);

        // R6 write while stopped, R4 stopped clock ignores ticks
        wr(8'h04, 8'h37);
        rd(8'h04, v); chk("R6", "stopped write", v, 8'h37);
        repeat (40) @(posedge clk);
        @(negedge clk);
        rd(8'h00, v); chk("R4", "stopped sec frozen", v, 8'h00);
        rd(8'h04, v); chk("R4", "stopped min frozen", v, 8'h37);
        rd(8'h44, v); chk("R5", "busy low while stopped", v, 8'h00);

        // R4/R5 start, BUSY one tick before the update
        wr(8'h40, 8'h01);
        rd(8'h44, v); chk("R4", "run bit", v[1], 1);
        chk("R5", "busy after start", v[0], 0);
        repeat (TPS - 1) @(posedge clk);
        @(negedge clk);
        rd(8'h44, v); chk("R5", "busy before update", v[0], 1);
        rd(8'h00, v); chk("R5", "sec before update", v, 8'h00);
        @(posedge clk);
        @(negedge clk);
        rd(8'h00, v); chk("R5", "sec after update", v, 8'h01);
        rd(8'h44, v); chk("R5", "busy after update", v[0], 0);
        // R6 write while running, away from BUSY
        wr(8'h04, 8'h45);
        rd(8'h04, v); chk("R6", "running write", v, 8'h45);

        // R2 R3 R8 sweep across midnight and the year wrap
        s = 58; mi = 58; h = 23; d = 31; mo = 12; y = 99;
        load(s, mi, h, d, mo, y);
        wr(8'h40, 8'h01);
        for (int k = 0; k < 70; k++) begin
            logic ev_m, ev_h, ev_d;
            if (k == 0) wait_sec(1);
            else begin
                repeat (TPS - 1) @(posedge clk);
                @(negedge clk);
            end
            ev_m = 0; ev_h = 0; ev_d = 0;
            s++;
            if (s == 60) begin s = 0; mi++; ev_m = 1; end
            if (mi == 60) begin mi = 0; h++; ev_h = 1; end
            if (h == 24) begin h = 0; d++; ev_d = 1; end
            if (d > dim(mo, y)) begin d = 1; mo++; end
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
            rd(8'h00, v); chk("R2", "sweep sec", v, bcd(s));
            rd(8'h04, v); chk("R2", "sweep min", v, bcd(mi));
            rd(8'h08, v); chk("R2", "sweep hour", v, bcd(h));
            rd(8'h0C, v); chk("R3", "sweep day", v, bcd(d));
            rd(8'h10, v); chk("R3", "sweep month", v, bcd(mo));
            rd(8'h14, v); chk("R3", "sweep year", v, bcd(y));
            rd(8'h44, v);
            chk("R8", "event flags", int'(v[5:2]), {ev_d, ev_h, ev_m, 1'b1});
            wr(8'h44, 8'h3C);
        end

        // R3 last day and day before last for each month and several years
        for (int yi = 0; yi < 4; yi++) begin
            for (int m = 1; m <= 12; m++) begin
                for (int off = 0; off < 2; off++) begin
                    int dd, ed, em, ey;
                    y = years[yi];
                    dd = dim(m, y) - off;
                    ed = (off == 0) ? 1 : dd + 1;
                    em = (off == 0) ? ((m == 12) ? 1 : m + 1) : m;
                    ey = (off == 0 && m == 12) ? (y + 1) % 100 : y;
                    load(59, 59, 23, dd, m, y);
                    wr(8'h40, 8'h01);
                    wait_sec(1);
                    rd(8'h0C, v); chk("R3", "month-end day", v, bcd(ed));
                    rd(8'h10, v); chk("R3", "month-end month", v, bcd(em));
                    rd(8'h14, v); chk("R3", "month-end year", v, bcd(ey));
                    rd(8'h44, v); chk("R8", "day event", v[5], 1);
                end
            end
        end

        // R7 R9 alarm hit, interrupt, write-one-to-clear
        load(58, 30, 12, 15, 6, 24);
        load_alarm(0, 31, 12, 15, 6, 24);
        wr(8'h48, 8'h08);
        wr(8'h40, 8'h01);
        wait_sec(1);
        rd(8'h44, v); chk("R7", "no flag one second early", v[6], 0);
        chk("R9", "irq_alarm early", irq_alarm, 0);
        wait_sec(1);
        rd(8'h44, v); chk("R7", "alarm flag on match", v[6], 1);
        chk("R9", "irq_alarm on match", irq_alarm, 1);
        chk("R9", "irq_timer masked", irq_timer, 0);
        wr(8'h44, 8'h40);
        rd(8'h44, v); chk("R7", "alarm flag cleared", v[6], 0);
        chk("R9", "irq_alarm cleared", irq_alarm, 0);

        // R7 near miss in year only
        load(58, 30, 12, 15, 6, 24);
        load_alarm(0, 31, 12, 15, 6, 25);
        wr(8'h40, 8'h01);
        wait_sec(2);
        rd(8'h44, v); chk("R7", "year mismatch no flag", v[6], 0);
        chk("R7", "year mismatch no irq", irq_alarm, 0);

        // R9 alarm masked: flag set, output low
        load(59, 30, 12, 15, 6, 24);
        load_alarm(0, 31, 12, 15, 6, 24);
        wr(8'h48, 8'h00);
        wr(8'h40, 8'h01);
        wait_sec(1);
        rd(8'h44, v); chk("R9", "masked alarm flag", v[6], 1);
        chk("R9", "masked irq_alarm", irq_alarm, 0);

        // R9 timer interrupt and masking it afterwards
        wr(8'h44, 8'h7C);
        wr(8'h48, 8'h04);
        repeat (TPS - 2) @(posedge clk);
        @(negedge clk);
        chk("R9", "irq_timer after second", irq_timer, 1);
        wr(8'h48, 8'h00);
        chk("R9", "irq_timer masked", irq_timer, 0);
        rd(8'h44, v); chk("R9", "sec flag kept", v[2], 1);

        finish_run();
    end
endmodule